// File: doc/BRIEF.md
# Unit-Granular DMA Request Generator with Tail Padding

This block sits between a byte producer and a host DMA engine. Producer bytes are packed into 32-bit words and held in a word buffer, and the host drains that buffer through a plain synchronous read port. The host engine works in fixed units of `UNIT_BYTES` bytes (512 by default) and cannot be stopped once a unit has started. For that reason the block never signals "data present" with a level. It tracks how many buffered bytes have not yet been promised to the host. Each time a full unit of such bytes exists, it issues one request pulse and commits that unit.

The producer interface is valid/ready. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. While `in_ready` is low, the producer must hold `in_valid` and `in_data` steady. `in_ready` drops when the buffer and the word being packed are both full, and it stays low for good once end of data has been signalled.

After the `eod` strobe, zero bytes are appended to the stream until its length is a whole number of units. Requests keep flowing until the padded tail has been requested. A sticky `done` flag then reports that the host has read everything.

Top module: `dma_unit_feeder`

## Requirements
- R1: A byte is taken only when `in_valid` and `in_ready` are both high. `in_ready` is low when the buffer holds `FIFO_WORDS` words and three bytes wait in the packer, and it is low in every cycle after `eod` has been seen.
- R2: Every four accepted bytes form one word, with the first byte in bits [7:0] and the fourth in bits [31:24]. Words are read back in the order they were written.
- R3: A request pulse is started only when at least `UNIT_BYTES` bytes are buffered and not yet committed. Each pulse commits exactly `UNIT_BYTES` bytes, and a partial unit is never requested.
- R4: `dma_req` stays high for exactly `PULSE_LEN` cycles (default 2). It is then low for at least `GAP_LEN` cycles (default 2) before the next pulse.
- R5: Once the gap has passed, a further pulse follows as soon as another uncommitted unit exists, so N complete units yield N pulses without any host action.
- R6: After `eod`, a zero byte is inserted in each cycle where `in_valid` is low and room exists, until the stream length is a multiple of `UNIT_BYTES`. Nothing is padded while `in_valid` is high, and nothing is padded when the length is already a multiple.
- R7: `rd_data` shows the oldest word in the same cycle as `rd_en`, and that word is removed at the clock edge. A read of an empty buffer returns zero and sets the sticky `underflow` flag. `uf_clr` clears the flag, and a new underflow in the same cycle wins over the clear.
- R8: `units_req` counts the request pulses issued, saturating at its 14-bit maximum.
- R9: `done` goes high once `eod` has been seen, padding is complete, every unit has been requested and the buffer is empty. It stays high until reset. With no bytes at all, `eod` alone sets it.
- R10: After reset, `dma_req`, `done`, `underflow` and `units_req` are zero and `in_ready` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Producer byte |
| eod | input | 1 | One-cycle end-of-data strobe |
| rd_en | input | 1 | Host read of one word |
| rd_data | output | 32 | Oldest word, zero when empty |
| uf_clr | input | 1 | Clears the underflow flag |
| underflow | output | 1 | Sticky empty-read flag |
| dma_req | output | 1 | Unit request pulse |
| units_req | output | 14 | Number of pulses issued |
| done | output | 1 | Whole padded stream requested and drained |

## Verification
The two functions that collide are a host pop and a producer word push landing on the buffer in the same cycle. In that same cycle a unit can also be claimed while four new bytes are added to the uncommitted count. The bench provokes this by running the producer driver and the host reader in parallel after the buffer has filled, so that back-pressure releases exactly as reads start. Every word the host reads is compared against a scoreboard queue. The bench also checks that the number of pulses matches the count of whole units, and it measures each pulse width and gap.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_HIGH = 2'd1,
    PS_GAP  = 2'd2
  } pulse_state_e;

  function automatic int unsigned fdr_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fdr_packer.sv
module fdr_packer #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      byte_vld,
  input  logic [BYTE_W-1:0]         byte_data,
  output logic                      byte_rdy,
  input  logic                      word_room,
  output logic                      word_push,
  output logic [LANES*BYTE_W-1:0]   word_data
);
  localparam int CW = $clog2(LANES);

  logic [CW-1:0]     lane_q;
  logic [BYTE_W-1:0] hold_q [LANES-1];
  logic              last_lane;
  logic              take;

  assign last_lane = (lane_q == CW'(LANES-1));
  assign byte_rdy  = !last_lane || word_room;
  assign take      = byte_vld && byte_rdy;
  assign word_push = take && last_lane;

  generate
    for (genvar g = 0; g < LANES-1; g++) begin : g_lane
      assign word_data[g*BYTE_W +: BYTE_W] = hold_q[g];
      always_ff @(posedge clk) begin
        if (!rst_n) hold_q[g] <= '0;
        else if (take && (lane_q == CW'(g))) hold_q[g] <= byte_data;
      end
    end
  endgenerate
  assign word_data[(LANES-1)*BYTE_W +: BYTE_W] = byte_data;

  always_ff @(posedge clk) begin
    if (!rst_n) lane_q <= '0;
    else if (take) lane_q <= last_lane ? '0 : lane_q + 1'b1;
  end

  p_push_has_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |-> word_room);
endmodule

// File: rtl/fdr_word_fifo.sv
module fdr_word_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [WORD_W-1:0]         push_data,
  input  logic                      pop,
  output logic [WORD_W-1:0]         head,
  output logic                      empty,
  output logic                      full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH+1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [NW-1:0]     cnt_q;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == NW'(DEPTH));
  assign count = cnt_q;
  assign head  = mem[rptr_q];

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (pop)  rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/fdr_pulser.sv
module fdr_pulser
  import fdr_pkg::*;
#(
  parameter int PULSE_LEN  = 2,
  parameter int GAP_LEN    = 2,
  parameter int UNIT_BYTES = 512,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 12,
  parameter int UNIT_CNT_W = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_added,
  output logic                  req,
  output logic                  busy,
  output logic                  unc_zero,
  output logic [UNIT_CNT_W-1:0] units
);
  localparam int TW = $clog2(fdr_max(PULSE_LEN, GAP_LEN) + 1);
  localparam logic [CNT_W-1:0] CMAX  = '1;
  localparam logic [CNT_W-1:0] CUNIT = CNT_W'(UNIT_BYTES);
  localparam logic [CNT_W-1:0] CWORD = CNT_W'(WORD_BYTES);

  pulse_state_e          st_q;
  logic [TW-1:0]         tmr_q;
  logic [CNT_W-1:0]      unc_q, unc_nx;
  logic [UNIT_CNT_W-1:0] units_q;
  logic                  claim;

  assign claim    = (st_q == PS_IDLE) && (unc_q >= CUNIT);
  assign req      = (st_q == PS_HIGH);
  assign busy     = req;
  assign unc_zero = (unc_q == '0);
  assign units    = units_q;

  always_comb begin
    unc_nx = unc_q;
    if (claim) unc_nx = unc_nx - CUNIT;
    if (word_added) unc_nx = (unc_nx > CMAX - CWORD) ? CMAX : unc_nx + CWORD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= PS_IDLE;
      tmr_q   <= '0;
      unc_q   <= '0;
      units_q <= '0;
    end else begin
      unc_q <= unc_nx;
      if (claim && (units_q != '1)) units_q <= units_q + 1'b1;
      case (st_q)
        PS_IDLE: begin
          tmr_q <= '0;
          if (claim) st_q <= PS_HIGH;
        end
        PS_HIGH: begin
          if (tmr_q == TW'(PULSE_LEN-1)) begin
            st_q  <= PS_GAP;
            tmr_q <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        end
        PS_GAP: begin
          if (tmr_q == TW'(GAP_LEN-1)) begin
            st_q  <= PS_IDLE;
            tmr_q <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  p_claim_needs_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(unc_q) >= CUNIT);
  p_low_after_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |=> !req);
  p_units_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> (units_q == $past(units_q) + 1'b1) || ($past(units_q) == '1));
endmodule

// File: rtl/dma_unit_feeder.sv
module dma_unit_feeder #(
  parameter int FIFO_WORDS = 256,
  parameter int PULSE_LEN  = 2,
  parameter int GAP_LEN    = 2,
  parameter int UNIT_BYTES = 512,
  parameter int UNIT_CNT_W = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [7:0]            in_data,
  input  logic                  eod,
  input  logic                  rd_en,
  output logic [31:0]           rd_data,
  input  logic                  uf_clr,
  output logic                  underflow,
  output logic                  dma_req,
  output logic [UNIT_CNT_W-1:0] units_req,
  output logic                  done
);
  localparam int LANES = 4;
  localparam int PH_W  = $clog2(UNIT_BYTES);
  localparam int CNT_W = $clog2(FIFO_WORDS*LANES + 1) + 1;
  localparam int NW    = $clog2(FIFO_WORDS + 1);

  logic            eod_seen_q, uf_q, done_q;
  logic [PH_W-1:0] phase_q;
  logic            pad_go, src_vld, pk_rdy, take;
  logic [7:0]      src_data;
  logic            w_push, f_empty, f_full, pop;
  logic [31:0]     w_data, f_head;
  logic [NW-1:0]   f_count;
  logic            p_busy, p_unc_zero;

  assign pad_go   = eod_seen_q && !in_valid && (phase_q != '0);
  assign src_vld  = (in_valid && !eod_seen_q) || pad_go;
  assign src_data = eod_seen_q ? 8'h00 : in_data;
  assign in_ready = !eod_seen_q && pk_rdy;
  assign take     = src_vld && pk_rdy;
  assign pop      = rd_en && !f_empty;
  assign rd_data  = f_empty ? 32'h0 : f_head;

  fdr_packer #(.BYTE_W(8), .LANES(LANES)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .byte_vld(src_vld), .byte_data(src_data), .byte_rdy(pk_rdy),
    .word_room(!f_full), .word_push(w_push), .word_data(w_data)
  );

  fdr_word_fifo #(.WORD_W(32), .DEPTH(FIFO_WORDS)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(w_push), .push_data(w_data), .pop(pop),
    .head(f_head), .empty(f_empty), .full(f_full), .count(f_count)
  );

  fdr_pulser #(
    .PULSE_LEN(PULSE_LEN), .GAP_LEN(GAP_LEN), .UNIT_BYTES(UNIT_BYTES),
    .WORD_BYTES(LANES), .CNT_W(CNT_W), .UNIT_CNT_W(UNIT_CNT_W)
  ) u_pulse (
    .clk(clk), .rst_n(rst_n), .word_added(w_push),
    .req(dma_req), .busy(p_busy), .unc_zero(p_unc_zero), .units(units_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eod_seen_q <= 1'b0;
      phase_q    <= '0;
      uf_q       <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      if (eod) eod_seen_q <= 1'b1;
      if (take) phase_q <= phase_q + 1'b1;
      if (rd_en && f_empty) uf_q <= 1'b1;
      else if (uf_clr)      uf_q <= 1'b0;
      if (eod_seen_q && (phase_q == '0) && f_empty && p_unc_zero && !p_busy)
        done_q <= 1'b1;
    end
  end

  assign underflow = uf_q;
  assign done      = done_q;

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_q) |-> done_q);
  p_uf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(uf_q) && !$past(uf_clr)) |-> uf_q);
  p_done_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (f_count == '0) || $past(done_q));
endmodule

// File: tb/test_dma_unit_feeder.sv
module test_dma_unit_feeder;
  localparam int UNIT_WORDS = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        eod = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        uf_clr = 1'b0;
  logic        underflow;
  logic        dma_req;
  logic [13:0] units_req;
  logic        done;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  int p0 = 0;
  int got = 0;
  bit sb_on = 1'b1;
  bit seen_pulse = 1'b0;
  int hi_len = 0;
  int lo_len = 0;
  bit finished = 1'b0;
  logic [31:0] q [$];
  logic [31:0] wacc;

  always #10 clk = ~clk;

  dma_unit_feeder i_dma_unit_feeder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .eod(eod), .rd_en(rd_en), .rd_data(rd_data),
    .uf_clr(uf_clr), .underflow(underflow), .dma_req(dma_req),
    .units_req(units_req), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  // pulse monitor: widths and gaps (R4), counting (R5)
  always @(negedge clk) begin
    if (dma_req) begin
      if (hi_len == 0) begin
        pulses++;
        if (seen_pulse) begin
          checks++;
          if (lo_len < 2) begin
            errors++;
            $display("FAIL R4 gap actual=%0d expected>=2", lo_len);
          end
        end
        seen_pulse = 1'b1;
      end
      hi_len++;
      lo_len = 0;
    end else begin
      if (hi_len != 0) chk("R4 width", 32'(hi_len), 32'd2);
      hi_len = 0;
      lo_len++;
    end
  end

  // scoreboard monitor (R2)
  always @(negedge clk) begin
    #5;
    if (rd_en && sb_on) begin
      if (q.size() == 0) chk("R2 unexpected read", rd_data, 32'hxxxxxxxx);
      else chk("R2 word", rd_data, q.pop_front());
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    p0 = pulses;
    got = 0;
    @(negedge clk);
  endtask

  task automatic send_range(input int lo, input int hi);
    for (int i = lo; i < hi; i++) begin
      in_valid = 1'b1;
      in_data  = pat(i);
      wacc[8*(i%4) +: 8] = pat(i);
      if ((i % 4) == 3) q.push_back(wacc);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic read_units(input int n);
    for (int u = 0; u < n; u++) begin
      while ((pulses - p0) <= got) @(negedge clk);
      for (int w = 0; w < UNIT_WORDS; w++) begin
        @(negedge clk);
        rd_en = 1'b1;
      end
      @(negedge clk);
      rd_en = 1'b0;
      got++;
    end
  endtask

  task automatic pulse_eod();
    @(negedge clk);
    eod = 1'b1;
    @(negedge clk);
    eod = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 dma_req", 32'(dma_req), 0);
    chk("R10 in_ready", 32'(in_ready), 1);
    chk("R10 done", 32'(done), 0);
    chk("R10 underflow", 32'(underflow), 0);
    chk("R10 units_req", 32'(units_req), 0);

    // fill without host reads: back-pressure (R1), two pulses (R3, R5)
    send_range(0, 1027);
    chk("R1 in_ready low when full", 32'(in_ready), 0);
    repeat (20) @(negedge clk);
    chk("R5 back-to-back pulses", 32'(pulses - p0), 2);
    chk("R8 units_req", 32'(units_req), 2);

    // producer and host concurrently: push and pop in one cycle
    fork
      send_range(1027, 1300);
      read_units(2);
    join
    repeat (20) @(negedge clk);
    chk("R3 partial unit not requested", 32'(pulses - p0), 2);

    // eod, then hold in_valid high: no padding (R6), port closed (R1)
    pulse_eod();
    in_valid = 1'b1;
    in_data  = 8'hFF;
    repeat (20) @(negedge clk);
    chk("R6 no pad while valid", 32'(pulses - p0), 2);
    chk("R1 in_ready low after eod", 32'(in_ready), 0);
    in_valid = 1'b0;
    for (int k = 0; k < (1536 - 1300) / 4; k++) q.push_back(32'h0);
    read_units(1);
    repeat (5) @(negedge clk);
    chk("R6 padded unit requested", 32'(pulses - p0), 3);
    chk("R8 units_req final", 32'(units_req), 3);
    chk("R9 done", 32'(done), 1);
    chk("R2 scoreboard drained", 32'(q.size()), 0);

    // empty read (R7)
    sb_on = 1'b0;
    @(negedge clk);
    rd_en = 1'b1;
    #5 chk("R7 empty read data", rd_data, 32'h0);
    @(negedge clk);
    rd_en = 1'b0;
    #5 chk("R7 underflow set", 32'(underflow), 1);
    repeat (3) @(negedge clk);
    chk("R7 underflow sticky", 32'(underflow), 1);
    chk("R9 done sticky", 32'(done), 1);
    uf_clr = 1'b1;
    @(negedge clk);
    uf_clr = 1'b0;
    #5 chk("R7 underflow cleared", 32'(underflow), 0);
    sb_on = 1'b1;

    // exact unit then eod: no padding (R6)
    do_reset();
    chk("R10 units after reset", 32'(units_req), 0);
    send_range(0, 512);
    pulse_eod();
    read_units(1);
    repeat (20) @(negedge clk);
    chk("R6 no pad when aligned", 32'(pulses - p0), 1);
    chk("R9 done aligned", 32'(done), 1);
    chk("R2 scoreboard drained aligned", 32'(q.size()), 0);

    // eod with no data (R9)
    do_reset();
    chk("R9 done low before eod", 32'(done), 0);
    pulse_eod();
    repeat (5) @(negedge clk);
    chk("R9 done empty stream", 32'(done), 1);
    chk("R3 no pulse empty stream", 32'(pulses - p0), 0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule